// File: doc/BRIEF.md
# E1 Overhead Alarm Bit Monitor

This block watches an E1 stream whose frame and multiframe alignment have already been found, and turns three overhead alarm bits into steady, filtered flags. The upstream framer supplies a bit strobe, the data bit, the bit's position in the 256-bit frame, whether the frame carries the alignment word, the frame number inside the 16-frame signalling multiframe, and a flag that says whether alignment is currently trusted.

Three filters run side by side. The first is the remote alarm bit in frames without the alignment word, which uses a three-in-a-row rule in both directions. The second is the distant multiframe alarm bit in timeslot 16 of multiframe frame 0, which uses a two-in-a-row rule. The third is the Sa7 spare bit, which feeds a vote over its last three values and raises a V5.2 link indication. While alignment is not trusted, the filters forget their partial evidence and the flags keep their last value.

Top module: `e1_alarm_mon`

## Requirements
- R1: After reset all three flags (`remote_alarm`, `dist_mf_alarm`, `sa7_link`) are 0.
- R2: `remote_alarm` becomes 1 when bit position 2 carries a 1 in three consecutive non-align frames (`align_frame` = 0).
- R3: `remote_alarm` becomes 0 when bit position 2 carries a 0 in three consecutive non-align frames.
- R4: `dist_mf_alarm` becomes 1 when bit position 133 of a frame with `mf_num` = 0 carries a 1 in two consecutive multiframes.
- R5: `dist_mf_alarm` becomes 0 when that bit carries a 0 in two consecutive multiframes.
- R6: The Sa7 bit is bit position 6 of non-align frames. A three-deep history records it, and `sa7_link` is 1 exactly when two or more of the three stored values are 0. The history holds 1s after reset and after loss of sync.
- R7: In any cycle with `sync_ok` = 0, the three flags keep their value, the run counters of R2 to R5 restart from zero, and the Sa7 history returns to all ones.
- R8: Bits are ignored when `bit_en` = 0, when they fall at any other bit position, when they fall in align frames (for R2, R3 and R6), or when `mf_num` is not 0 (for R4 and R5).
- R9: Each flag is registered. It changes on the clock edge that samples the deciding bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One received bit is present in this cycle |
| data_bit | input | 1 | Received bit value |
| bit_pos | input | 8 | Bit position inside the frame, 0 to 255, MSB first per timeslot |
| align_frame | input | 1 | 1 when the current frame carries the alignment word |
| mf_num | input | 4 | Frame number inside the signalling multiframe |
| sync_ok | input | 1 | Frame and multiframe alignment are valid |
| remote_alarm | output | 1 | Filtered remote alarm flag |
| dist_mf_alarm | output | 1 | Filtered distant multiframe alarm flag |
| sa7_link | output | 1 | Sa7 two-of-three zero vote |

## Verification
The hardest case to reach is a run that is cut off by loss of sync. For example, two alarm bits arrive, sync drops, and then one more bit arrives. A correct design must not raise the flag, yet the flag must still hold its old value. The bench drives a pseudo-random mix of non-align frames, multiframe-0 frames and single-cycle sync drops, and it tracks the expected counters and history in its own model. It also sweeps every 6-bit pattern for the remote and Sa7 bits and every 5-bit pattern for the multiframe bit. Decoy bits at neighbouring positions, in align frames and with other frame numbers are placed between the real slots.

// File: rtl/e1_alarm_pkg.sv
package e1_alarm_pkg;
    localparam int FRAME_BITS = 256;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int MF_W       = 4;

    typedef logic [POS_W-1:0] bitpos_t;
    typedef logic [MF_W-1:0]  mfnum_t;
endpackage

// File: rtl/e1_run_filter.sv
module e1_run_filter #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic smp,
    input  logic val,
    output logic flag
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

    typedef struct packed {
        logic [CW-1:0] ones;
        logic [CW-1:0] zeros;
        logic          flag;
    } run_st_t;

    run_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ones  = '0;
            st_d.zeros = '0;
        end else if (smp) begin
            if (val) begin
                st_d.zeros = '0;
                if (st_q.ones != LIMIT) st_d.ones = st_q.ones + CW'(1);
                if (st_d.ones == LIMIT) st_d.flag = 1'b1;
            end else begin
                st_d.ones = '0;
                if (st_q.zeros != LIMIT) st_d.zeros = st_q.zeros + CW'(1);
                if (st_d.zeros == LIMIT) st_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/e1_zero_vote.sv
module e1_zero_vote #(
    parameter int DEPTH     = 3,
    parameter int MIN_ZEROS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic smp,
    input  logic val,
    output logic flag
);
    localparam int ZW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0] hist;
        logic             flag;
    } vote_st_t;

    vote_st_t st_d, st_q;
    logic [ZW-1:0] zero_cnt;

    always_comb begin
        st_d     = st_q;
        zero_cnt = '0;
        if (clr) begin
            st_d.hist = '1;
        end else if (smp) begin
            st_d.hist = {st_q.hist[DEPTH-2:0], val};
            for (int i = 0; i < DEPTH; i++) begin
                if (!st_d.hist[i]) zero_cnt = zero_cnt + ZW'(1);
            end
            st_d.flag = (zero_cnt >= ZW'(MIN_ZEROS));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hist <= '1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/e1_alarm_mon.sv
module e1_alarm_mon
    import e1_alarm_pkg::*;
#(
    parameter int RAI_POS     = 2,
    parameter int SA7_POS     = 6,
    parameter int MFA_POS     = 133,
    parameter int RAI_RUN     = 3,
    parameter int MFA_RUN     = 2,
    parameter int VOTE_DEPTH  = 3,
    parameter int VOTE_ZEROS  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       data_bit,
    input  logic [7:0] bit_pos,
    input  logic       align_frame,
    input  logic [3:0] mf_num,
    input  logic       sync_ok,
    output logic       remote_alarm,
    output logic       dist_mf_alarm,
    output logic       sa7_link
);
    logic live;
    logic rai_smp, sa7_smp, mfa_smp;

    always_comb begin
        live    = bit_en && sync_ok;
        rai_smp = live && !align_frame && (bit_pos == bitpos_t'(RAI_POS));
        sa7_smp = live && !align_frame && (bit_pos == bitpos_t'(SA7_POS));
        mfa_smp = live && (mf_num == '0) && (bit_pos == bitpos_t'(MFA_POS));
    end

    e1_run_filter #(.RUN_LEN(RAI_RUN)) u_rai (
        .clk(clk), .rst_n(rst_n), .clr(!sync_ok),
        .smp(rai_smp), .val(data_bit), .flag(remote_alarm)
    );

    e1_run_filter #(.RUN_LEN(MFA_RUN)) u_mfa (
        .clk(clk), .rst_n(rst_n), .clr(!sync_ok),
        .smp(mfa_smp), .val(data_bit), .flag(dist_mf_alarm)
    );

    e1_zero_vote #(.DEPTH(VOTE_DEPTH), .MIN_ZEROS(VOTE_ZEROS)) u_sa7 (
        .clk(clk), .rst_n(rst_n), .clr(!sync_ok),
        .smp(sa7_smp), .val(data_bit), .flag(sa7_link)
    );
endmodule

// File: rtl/e1_alarm_mon_chk.sv
module e1_alarm_mon_chk #(
    parameter int RAI_POS = 2,
    parameter int SA7_POS = 6,
    parameter int MFA_POS = 133
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       data_bit,
    input logic [7:0] bit_pos,
    input logic       align_frame,
    input logic [3:0] mf_num,
    input logic       sync_ok,
    input logic       remote_alarm,
    input logic       dist_mf_alarm,
    input logic       sa7_link
);
    logic rai_slot, sa7_slot, mfa_slot;
    assign rai_slot = bit_en && sync_ok && !align_frame && (bit_pos == 8'(RAI_POS));
    assign sa7_slot = bit_en && sync_ok && !align_frame && (bit_pos == 8'(SA7_POS));
    assign mfa_slot = bit_en && sync_ok && (mf_num == 4'd0) && (bit_pos == 8'(MFA_POS));

    AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> !remote_alarm && !dist_mf_alarm && !sa7_link); // R1
    AST_RAI_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(remote_alarm) |-> $past(rai_slot && data_bit)); // R2
    AST_RAI_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(remote_alarm) |-> $past(rai_slot && !data_bit)); // R3
    AST_MFA_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(dist_mf_alarm) |-> $past(mfa_slot && data_bit)); // R4
    AST_MFA_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(dist_mf_alarm) |-> $past(mfa_slot && !data_bit)); // R5
    AST_SA7_MOVE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sa7_link) |-> $past(sa7_slot)); // R6
    AST_NOSYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !sync_ok |=> $stable({remote_alarm, dist_mf_alarm, sa7_link})); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bit_en |=> $stable({remote_alarm, dist_mf_alarm, sa7_link})); // R8
endmodule

bind e1_alarm_mon e1_alarm_mon_chk #(
    .RAI_POS(RAI_POS), .SA7_POS(SA7_POS), .MFA_POS(MFA_POS)
) u_chk (.*);

// File: tb/e1_alarm_mon_bench.sv
module e1_alarm_mon_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       data_bit = 1'b0;
    logic [7:0] bit_pos = '0;
    logic       align_frame = 1'b0;
    logic [3:0] mf_num = 4'd1;
    logic       sync_ok = 1'b1;
    logic       remote_alarm, dist_mf_alarm, sa7_link;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_r1 = 0, m_r0 = 0, m_m1 = 0, m_m0 = 0;
    bit m_rf = 0, m_mf = 0, m_vf = 0;
    bit [2:0] m_h = 3'b111;
    bit [15:0] lfsr = 16'hACE1;

    always #(CLK_P/2) clk = ~clk;

    e1_alarm_mon u_e1_alarm_mon (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .data_bit(data_bit),
        .bit_pos(bit_pos), .align_frame(align_frame), .mf_num(mf_num),
        .sync_ok(sync_ok), .remote_alarm(remote_alarm),
        .dist_mf_alarm(dist_mf_alarm), .sa7_link(sa7_link)
    );

    task automatic chk(input logic got, input bit exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic chk_all(input string req);
        chk(remote_alarm, m_rf, req);
        chk(dist_mf_alarm, m_mf, req);
        chk(sa7_link, m_vf, req);
    endtask

    // one cycle of stimulus, outputs are valid at the following negedge
    task automatic slot(input bit en, input int pos, input bit al, input int mf,
                        input bit d, input bit sy);
        @(negedge clk);
        bit_en = en; bit_pos = 8'(pos); align_frame = al;
        mf_num = 4'(mf); data_bit = d; sync_ok = sy;
        @(negedge clk);
        bit_en = 1'b0; sync_ok = 1'b1;
    endtask

    task automatic mdl_rai(input bit b);
        if (b) begin m_r0 = 0; if (m_r1 < 3) m_r1++; if (m_r1 == 3) m_rf = 1; end
        else   begin m_r1 = 0; if (m_r0 < 3) m_r0++; if (m_r0 == 3) m_rf = 0; end
    endtask

    task automatic mdl_mfa(input bit b);
        if (b) begin m_m0 = 0; if (m_m1 < 2) m_m1++; if (m_m1 == 2) m_mf = 1; end
        else   begin m_m1 = 0; if (m_m0 < 2) m_m0++; if (m_m0 == 2) m_mf = 0; end
    endtask

    task automatic mdl_sa7(input bit b);
        int z;
        m_h = {m_h[1:0], b};
        z = (m_h[0] ? 0 : 1) + (m_h[1] ? 0 : 1) + (m_h[2] ? 0 : 1);
        m_vf = (z >= 2);
    endtask

    // one non-align frame: remote alarm bit, decoys, Sa7 bit
    task automatic nafs(input bit rb, input bit sb);
        slot(1, 2, 0, 3, rb, 1); mdl_rai(rb);
        chk_all("R2/R3 remote run R9");                   // R2 R3 R9
        slot(1, 3, 0, 3, !rb, 1);   chk_all("R8 neighbour pos");     // R8
        slot(1, 2, 1, 3, !rb, 1);   chk_all("R8 align frame");       // R8
        slot(0, 2, 0, 3, !rb, 1);   chk_all("R8 bit_en low");        // R8
        slot(1, 6, 0, 3, sb, 1); mdl_sa7(sb);
        chk_all("R6 Sa7 vote");                           // R6
        slot(1, 6, 1, 3, !sb, 1);   chk_all("R8 Sa7 in align frame"); // R8
    endtask

    task automatic mf0(input bit b);
        slot(1, 133, 1, 0, b, 1); mdl_mfa(b);
        chk_all("R4/R5 multiframe run");                  // R4 R5
        slot(1, 133, 1, 7, !b, 1);  chk_all("R8 mf_num nonzero");    // R8
        slot(1, 132, 1, 0, !b, 1);  chk_all("R8 pos 132");           // R8
    endtask

    task automatic drop_sync(input bit d);
        slot(1, 2, 0, 0, d, 0);
        m_r1 = 0; m_r0 = 0; m_m1 = 0; m_m0 = 0; m_h = 3'b111;
        chk_all("R7 sync loss hold");                     // R7
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset state");                        // R1

        // R7: a run broken by sync loss must restart
        nafs(1, 1); nafs(1, 1); drop_sync(1); nafs(1, 1);
        chk(remote_alarm, 1'b0, "R7 restart after sync loss");
        nafs(1, 1); nafs(1, 1);
        chk(remote_alarm, 1'b1, "R2 set after three ones");

        // sweep all 6-bit patterns for remote alarm and Sa7
        for (int p = 0; p < 64; p++) begin
            for (int i = 0; i < 6; i++) nafs(p[i], p[(i + 3) % 6]);
        end

        // sweep all 5-bit patterns for the multiframe alarm bit
        for (int p = 0; p < 32; p++) begin
            for (int i = 0; i < 5; i++) mf0(p[i]);
        end

        // mixed traffic with sync drops
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0, 3'd1, 3'd2: nafs(lfsr[5], lfsr[7]);
                3'd3, 3'd4, 3'd5: mf0(lfsr[6]);
                default:          drop_sync(lfsr[8]);
            endcase
        end

        finish_run();
    end
endmodule